// File: doc/BRIEF.md
# Quadrature Oscillator and Complex Down-Mixer

This block turns a real, signed sampled intermediate-frequency stream into a complex baseband pair. A phase accumulator advances by a programmable step on every clock. The top bits of the running phase address a sine table, and the cosine is read from the same table a quarter turn further on. Each accepted input sample is multiplied by the cosine to give the in-phase output and by the negated sine to give the quadrature output. Together these form a multiplication by cos(wt) − j·sin(wt).

The output frequency is the step value times the clock rate divided by 2^28. Software, or a neighbouring controller, can change the step at any time through a one-cycle load strobe, and the oscillator phase keeps running through the change. The table is computed from a closed-form sine when the design is elaborated, so no memory image is needed. Products are cut back to the output width by dropping the redundant sign bit at the top and truncating the fraction bits at the bottom.

Top module: `nco_quad_mixer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0, `i_out` and `q_out` are 0, and both the phase and the step word are 0.
- R2: The 28-bit phase adds the current step word on every rising clock edge, modulo 2^28, whether or not a sample is valid.
- R3: The table address is phase bits [27:18]. Sine entry k equals round(32767·sin(2πk/1024)), and the cosine for address a is sine entry (a+256) mod 1024. No entry equals −32768.
- R4: `i_out` equals floor(x·cos/2^15), taken as a 16-bit signed value, where x is the sample.
- R5: `q_out` equals floor(−(x·sin)/2^15), taken as a 16-bit signed value.
- R6: `out_valid` is `in_valid` delayed by two rising edges. `i_out` and `q_out` change only in cycles where `out_valid` is high, and otherwise hold their last result.
- R7: A `fcw_load` pulse captures `fcw_in`. The phase update on that same edge still uses the old step, later updates use the new step, and the phase itself is not reset.
- R8: A sample captured on an edge is mixed with the carrier addressed by the phase value held just before that edge.
- R9: Full-scale inputs, including −32768, never produce −32768 on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fcw_load | input | 1 | One-cycle strobe that captures a new step word |
| fcw_in | input | 28 | Phase step (frequency control word) |
| in_valid | input | 1 | Marks `in_sample` as valid this cycle |
| in_sample | input | 16 | Signed real input sample |
| out_valid | output | 1 | Marks `i_out`/`q_out` as a new result |
| i_out | output | 16 | Signed in-phase result |
| q_out | output | 16 | Signed quadrature result |

## Verification
The bench builds the block with its default parameters: a 28-bit phase, a 1024-entry table, and 16-bit samples, amplitudes and outputs. A step of 2^18 walks exactly one table entry per clock, so 1024 consecutive full-scale samples visit every sine and cosine entry. Steps that are not multiples of 2^18 exercise truncation of the low phase bits, and an all-ones step makes the phase run backwards and wrap. Full-scale positive and negative samples reach the extreme products that R9 bounds.

// File: rtl/nco_mix_pkg.sv
package nco_mix_pkg;

    // Rounded sine code for table slot idx out of depth, at amplitude width amp_w.
    function automatic int sine_code(input int idx, input int depth, input int amp_w);
        real two_pi;
        real full;
        real ang;
        two_pi = 6.283185307179586;
        full   = real'((1 << (amp_w - 1)) - 1);
        ang    = two_pi * real'(idx) / real'(depth);
        return $rtoi($floor(full * $sin(ang) + 0.5));
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int PHASE_W = 28
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               fcw_load,
    input  logic [PHASE_W-1:0] fcw_in,
    output logic [PHASE_W-1:0] phase_o,
    output logic [PHASE_W-1:0] step_o
);

    logic [PHASE_W-1:0] phase_q;
    logic [PHASE_W-1:0] step_q;

    // Step register: a new word is used from the next update onward.
    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= '0;
        end else if (fcw_load) begin
            step_q <= fcw_in;
        end
    end

    // Phase runs on every clock and wraps naturally.
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + step_q;
        end
    end

    assign phase_o = phase_q;
    assign step_o  = step_q;

endmodule

// File: rtl/nco_sincos_rom.sv
module nco_sincos_rom #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 16
) (
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] sin_o,
    output logic signed [AMP_W-1:0] cos_o
);

    import nco_mix_pkg::*;

    localparam int TBL_DEPTH = 1 << ADDR_W;
    localparam int QUARTER   = TBL_DEPTH / 4;

    logic signed [AMP_W-1:0] tbl [TBL_DEPTH];
    logic [ADDR_W-1:0]       cos_addr;

    for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_entry
        localparam int CODE = sine_code(g, TBL_DEPTH, AMP_W);
        assign tbl[g] = AMP_W'(CODE);
    end

    assign cos_addr = addr + ADDR_W'(QUARTER);
    assign sin_o    = tbl[addr];
    assign cos_o    = tbl[cos_addr];

endmodule

// File: rtl/nco_mix_lane.sv
module nco_mix_lane #(
    parameter int DIN_W  = 16,
    parameter int AMP_W  = 16,
    parameter int DOUT_W = 16,
    parameter bit NEGATE = 1'b0
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     en,
    input  logic signed [DIN_W-1:0]  sample,
    input  logic signed [AMP_W-1:0]  carrier,
    output logic signed [DOUT_W-1:0] y_o
);

    localparam int PROD_W = DIN_W + AMP_W;
    localparam int SHIFT  = AMP_W - 1;

    logic signed [PROD_W-1:0] xs;
    logic signed [PROD_W-1:0] cs;
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] prod_sel;
    logic                     prod_unused;

    assign xs   = PROD_W'(sample);
    assign cs   = PROD_W'(carrier);
    assign prod = xs * cs;

    if (NEGATE) begin : g_neg
        assign prod_sel = -prod;
    end else begin : g_pos
        assign prod_sel = prod;
    end

    assign prod_unused = ^prod_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            y_o <= '0;
        end else if (en) begin
            y_o <= prod_sel[SHIFT +: DOUT_W];
        end
    end

endmodule

// File: rtl/nco_quad_mixer.sv
module nco_quad_mixer #(
    parameter int PHASE_W = 28,
    parameter int ADDR_W  = 10,
    parameter int AMP_W   = 16,
    parameter int DIN_W   = 16,
    parameter int DOUT_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     fcw_load,
    input  logic [PHASE_W-1:0]       fcw_in,
    input  logic                     in_valid,
    input  logic signed [DIN_W-1:0]  in_sample,
    output logic                     out_valid,
    output logic signed [DOUT_W-1:0] i_out,
    output logic signed [DOUT_W-1:0] q_out
);

    localparam int LANES = 2;

    logic [PHASE_W-1:0]      phase;
    logic [PHASE_W-1:0]      step;
    logic [ADDR_W-1:0]       rom_addr;
    logic signed [AMP_W-1:0] rom_sin;
    logic signed [AMP_W-1:0] rom_cos;
    logic                    phase_unused;

    logic                    s1_vld;
    logic signed [DIN_W-1:0] s1_x;
    logic signed [AMP_W-1:0] s1_car [LANES];
    logic signed [DOUT_W-1:0] lane_y [LANES];

    nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .fcw_load (fcw_load),
        .fcw_in   (fcw_in),
        .phase_o  (phase),
        .step_o   (step)
    );

    assign rom_addr     = phase[PHASE_W-1 -: ADDR_W];
    assign phase_unused = ^{phase, step};

    nco_sincos_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .addr  (rom_addr),
        .sin_o (rom_sin),
        .cos_o (rom_cos)
    );

    // Capture stage: sample and both carriers for the current phase.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_vld    <= 1'b0;
            s1_x      <= '0;
            s1_car[0] <= '0;
            s1_car[1] <= '0;
        end else begin
            s1_vld <= in_valid;
            if (in_valid) begin
                s1_x      <= in_sample;
                s1_car[0] <= rom_cos;
                s1_car[1] <= rom_sin;
            end
        end
    end

    // Lane 0 is in-phase (cosine), lane 1 quadrature (negated sine).
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        nco_mix_lane #(
            .DIN_W  (DIN_W),
            .AMP_W  (AMP_W),
            .DOUT_W (DOUT_W),
            .NEGATE (l == 1)
        ) u_lane (
            .clk     (clk),
            .rst     (rst),
            .en      (s1_vld),
            .sample  (s1_x),
            .carrier (s1_car[l]),
            .y_o     (lane_y[l])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= s1_vld;
        end
    end

    assign i_out = lane_y[0];
    assign q_out = lane_y[1];

endmodule

// File: rtl/nco_quad_mixer_chk.sv
module nco_quad_mixer_chk #(
    parameter int PHASE_W = 28,
    parameter int AMP_W   = 16,
    parameter int DOUT_W  = 16
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     fcw_load,
    input logic [PHASE_W-1:0]       fcw_in,
    input logic                     in_valid,
    input logic                     out_valid,
    input logic signed [DOUT_W-1:0] i_out,
    input logic signed [DOUT_W-1:0] q_out,
    input logic [PHASE_W-1:0]       phase,
    input logic [PHASE_W-1:0]       step,
    input logic signed [AMP_W-1:0]  rom_sin
);

    localparam logic signed [DOUT_W-1:0] OUT_MIN = {1'b1, {(DOUT_W-1){1'b0}}};
    localparam logic signed [AMP_W-1:0]  AMP_MIN = {1'b1, {(AMP_W-1){1'b0}}};

    AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && i_out == '0 && q_out == '0 && phase == '0 && step == '0)); // R1

    AST_STEP_LOAD: assert property (@(posedge clk) disable iff (rst) fcw_load |=> step == $past(fcw_in)); // R7

    AST_VALID_PIPE: assert property (@(posedge clk) disable iff (rst) in_valid |=> ##1 out_valid); // R6

    AST_IDLE_PIPE: assert property (@(posedge clk) disable iff (rst) !in_valid |=> ##1 !out_valid); // R6

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) !out_valid |-> ($stable(i_out) && $stable(q_out))); // R6

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) out_valid |-> (i_out != OUT_MIN && q_out != OUT_MIN)); // R9

    AST_TBL_RANGE: assert property (@(posedge clk) disable iff (rst) rom_sin != AMP_MIN); // R3

endmodule

bind nco_quad_mixer nco_quad_mixer_chk #(
    .PHASE_W (PHASE_W),
    .AMP_W   (AMP_W),
    .DOUT_W  (DOUT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fcw_load  (fcw_load),
    .fcw_in    (fcw_in),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .i_out     (i_out),
    .q_out     (q_out),
    .phase     (phase),
    .step      (step),
    .rom_sin   (rom_sin)
);

// File: tb/nco_quad_mixer_bench.sv
module nco_quad_mixer_bench;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               fcw_load = 1'b0;
    logic [27:0]        fcw_in = '0;
    logic               in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic               out_valid;
    logic signed [15:0] i_out;
    logic signed [15:0] q_out;

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    bit    checking = 1'b0;
    bit    done     = 1'b0;
    string cur_req  = "R1";
    logic [15:0] lfsr = 16'hACE1;

    always #10 clk = ~clk;

    nco_quad_mixer u_nco_quad_mixer (
        .clk       (clk),
        .rst       (rst),
        .fcw_load  (fcw_load),
        .fcw_in    (fcw_in),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .out_valid (out_valid),
        .i_out     (i_out),
        .q_out     (q_out)
    );

    // Reference model state
    longint m_phase, m_step;
    bit     m1_vld, m2_vld;
    int     m1_x, m1_addr;
    int     m_i, m_q;

    function automatic int ref_sine(input int k);
        real v;
        v = 32767.0 * $sin(2.0 * 3.141592653589793 * real'(k % 1024) / 1024.0);
        return $rtoi($floor(v + 0.5));
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_phase = 0; m_step = 0;
            m1_vld = 0; m2_vld = 0; m1_x = 0; m1_addr = 0;
            m_i = 0; m_q = 0;
        end else begin
            if (m1_vld) begin
                longint pi_, pq_;
                pi_ = longint'(m1_x) * longint'(ref_sine(m1_addr + 256));
                pq_ = -(longint'(m1_x) * longint'(ref_sine(m1_addr)));
                m_i = int'(pi_ >>> 15);
                m_q = int'(pq_ >>> 15);
            end
            m2_vld = m1_vld;
            m1_vld = in_valid;
            if (in_valid) begin
                m1_x    = int'(in_sample);
                m1_addr = int'(m_phase >> 18);
            end
            m_phase = (m_phase + m_step) & 64'h0FFF_FFFF;
            if (fcw_load) m_step = longint'(fcw_in);
        end
    end

    task automatic check_int(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cycles);
        end
    endtask

    // Compare against the model on every falling edge.
    always @(negedge clk) begin
        if (checking && !done) begin
            check_int(cur_req, "out_valid", int'(out_valid), int'(m2_vld));
            check_int(cur_req, "i_out", int'(i_out), m_i);
            check_int(cur_req, "q_out", int'(q_out), m_q);
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
            finish_run();
        end
    end

    task automatic step_in(input bit v, input int x, input bit ld, input logic [27:0] w);
        @(negedge clk);
        in_valid  = v;
        in_sample = 16'(x);
        fcw_load  = ld;
        fcw_in    = w;
    endtask

    function automatic int next_rand();
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        return int'($signed(lfsr));
    endfunction

    initial begin
        // R1: reset values, checked during reset
        repeat (3) @(negedge clk);
        check_int("R1", "out_valid in reset", int'(out_valid), 0);
        check_int("R1", "i_out in reset", int'(i_out), 0);
        check_int("R1", "q_out in reset", int'(q_out), 0);
        rst = 1'b0;
        checking = 1'b1;

        // R3 R4 R5: one table entry per clock, full-scale positive input
        cur_req = "R3 R4 R5";
        step_in(0, 0, 1, 28'd1 << 18);
        for (int k = 0; k < 1030; k++) step_in(1, 32767, 0, '0);

        // R9: full-scale negative input, odd step
        cur_req = "R9";
        step_in(1, -32768, 1, (28'd3 << 18) + 28'd12345);
        for (int k = 0; k < 300; k++) step_in(1, (k % 2) ? -32768 : 32767, 0, '0);

        // R6: sparse valid, outputs must hold in idle cycles
        cur_req = "R6";
        for (int k = 0; k < 200; k++) step_in((k % 3) == 0, next_rand(), 0, '0);

        // R2: phase keeps running while no samples arrive
        cur_req = "R2";
        for (int k = 0; k < 37; k++) step_in(0, 0, 0, '0);
        for (int k = 0; k < 50; k++) step_in(1, next_rand(), 0, '0);

        // R7: frequent on-the-fly word changes under continuous valid
        cur_req = "R7";
        for (int k = 0; k < 240; k++)
            step_in(1, next_rand(), (k % 20) == 7, 28'(k * 987_654 + 4321));

        // R8: backward-running phase with wrap
        cur_req = "R8";
        step_in(1, next_rand(), 1, 28'hFFF_FFFF);
        for (int k = 0; k < 200; k++) step_in(1, next_rand(), 0, '0);
        step_in(1, 1000, 1, 28'h8F0_0000);
        for (int k = 0; k < 60; k++) step_in(1, next_rand(), 0, '0);

        // R1: reset in the middle of traffic
        cur_req = "R1";
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 40; k++) step_in(k > 5, next_rand(), k == 2, 28'd5 << 18);
        step_in(0, 0, 0, '0);
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule